// File: doc/BRIEF.md
# Two-Port Parity Generator and Checker

This block holds the parity decisions for one nine-bit lane of a two-way transceiver. Each side, A and B, carries eight data bits and one parity bit. The register path supplies the stored values for both sides. The block takes four controls: a parity-enable (active low), an odd/even select, and the two active-low direction enables.

From these controls the block decides, for each side, what the outgoing parity bit is. It can be generated from the data travelling toward that side, or passed through unchanged from the opposite side's stored parity. The block also decides whether the incoming word on each side is checked. Every side has an active-low error flag and a companion valid flag. The valid flag marks where a pad would drive the error pin, as opposed to leaving it floating.

The direction enables choose the mode:

| A-to-B enable | B-to-A enable | Mode |
|---|---|---|
| active | inactive | check A, generate for B |
| inactive | active | check B, generate for A |
| inactive | inactive | isolation: check both sides |
| active | active | generate for both sides |

When parity is disabled, the ninth bit is carried as plain data. The block holds no state; all outputs follow the inputs combinationally.

Top module: `lane_parity_unit`

## Requirements
- R1: While `par_off_n` is 1, parity is disabled. `par_to_b` equals `a_par` and `par_to_a` equals `b_par` (the ninth bit is passed through as data), and both `a_err_vld` and `b_err_vld` are 0.
- R2: When parity is enabled, `a_dir_n`=0 and `b_dir_n`=1 select the A-to-B mode. Side A is checked (`a_err_vld`=1), `par_to_b` is generated from `a_data`, and `b_err_vld`=0.
- R3: When parity is enabled, `a_dir_n`=1 and `b_dir_n`=0 select the B-to-A mode. Side B is checked (`b_err_vld`=1), `par_to_a` is generated from `b_data`, and `a_err_vld`=0.
- R4: When parity is enabled and both direction enables are 1 (isolation), both sides are checked. Both parity outputs pass their opposite side's stored parity bit through.
- R5: When parity is enabled and both direction enables are 0, both parity outputs are generated and neither side is checked.
- R6: In even mode (`odd_sel`=0), a generated parity bit is 0 when the number of ones in its eight source bits is even, and 1 when it is odd.
- R7: In odd mode (`odd_sel`=1), a generated parity bit is the inverse of the even-mode value.
- R8: In even mode, a checked side's error flag is 1 (no error) when its eight data ones plus its parity bit total an even count, and 0 otherwise.
- R9: In odd mode, a checked side's error flag is 1 when that total is odd, and 0 when it is even.
- R10: A side whose error valid flag is 0 holds its error flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| par_off_n | input | 1 | Parity enable, active low; 1 makes the ninth bit plain data |
| odd_sel | input | 1 | 0 selects even parity, 1 selects odd parity |
| a_dir_n | input | 1 | A-to-B direction enable, active low |
| b_dir_n | input | 1 | B-to-A direction enable, active low |
| a_data | input | DATA_W | Stored data word of side A |
| a_par | input | 1 | Stored parity bit of side A |
| b_data | input | DATA_W | Stored data word of side B |
| b_par | input | 1 | Stored parity bit of side B |
| par_to_b | output | 1 | Parity bit presented toward side B |
| par_to_a | output | 1 | Parity bit presented toward side A |
| a_err_n | output | 1 | Side A parity error flag, active low |
| a_err_vld | output | 1 | 1 when the side A error flag is driven |
| b_err_n | output | 1 | Side B parity error flag, active low |
| b_err_vld | output | 1 | 1 when the side B error flag is driven |

## Verification
The block has no internal state, so a wrong decode of the control inputs shows up in the same cycle. It appears as a parity bit that was generated where it should have been passed through, or the reverse, or as a valid flag raised on the side that is driving. A wrong sense of the odd/even select flips every generated bit and every error flag at once. A reduction that misses one data bit shows only for words whose ones count differs at that bit. The stimulus therefore sweeps every control combination against all-zero, all-one, single-bit and random words, each with parity both right and wrong.

// File: rtl/lane_parity_unit.sv
module lane_parity_unit #(
  parameter int DATA_W = 8
) (
  input  logic              par_off_n,
  input  logic              odd_sel,
  input  logic              a_dir_n,
  input  logic              b_dir_n,
  input  logic [DATA_W-1:0] a_data,
  input  logic              a_par,
  input  logic [DATA_W-1:0] b_data,
  input  logic              b_par,
  output logic              par_to_b,
  output logic              par_to_a,
  output logic              a_err_n,
  output logic              a_err_vld,
  output logic              b_err_n,
  output logic              b_err_vld
);

  logic par_on;
  logic gen_b, gen_a;
  logic a_fold, b_fold;

  assign par_on = ~par_off_n;

  // A side is checked whenever it is not being driven from B, and vice versa.
  assign a_err_vld = par_on & b_dir_n;
  assign b_err_vld = par_on & a_dir_n;
  assign gen_b     = par_on & ~a_dir_n;
  assign gen_a     = par_on & ~b_dir_n;

  assign a_fold = ^a_data;
  assign b_fold = ^b_data;

  assign par_to_b = gen_b ? (a_fold ^ odd_sel) : a_par;
  assign par_to_a = gen_a ? (b_fold ^ odd_sel) : b_par;

  assign a_err_n = a_err_vld ? ~(a_fold ^ a_par ^ odd_sel) : 1'b1;
  assign b_err_n = b_err_vld ? ~(b_fold ^ b_par ^ odd_sel) : 1'b1;

endmodule

// File: rtl/lane_parity_unit_chk.sv
module lane_parity_unit_chk #(
  parameter int DATA_W = 8
) (
  input logic              par_off_n,
  input logic              odd_sel,
  input logic              a_dir_n,
  input logic              b_dir_n,
  input logic [DATA_W-1:0] a_data,
  input logic              a_par,
  input logic [DATA_W-1:0] b_data,
  input logic              b_par,
  input logic              par_to_b,
  input logic              par_to_a,
  input logic              a_err_n,
  input logic              a_err_vld,
  input logic              b_err_n,
  input logic              b_err_vld
);

  always_comb begin
    if (par_off_n === 1'b1) begin
      a_r1_pass_thru: assert (par_to_b == a_par && par_to_a == b_par && !a_err_vld && !b_err_vld);
    end
    if (par_off_n === 1'b0 && a_dir_n === 1'b0 && b_dir_n === 1'b1) begin
      a_r2_ab_mode: assert (a_err_vld && !b_err_vld && (par_to_b ^ (^a_data)) == odd_sel);
    end
    if (par_off_n === 1'b0 && a_dir_n === 1'b1 && b_dir_n === 1'b0) begin
      a_r3_ba_mode: assert (b_err_vld && !a_err_vld && (par_to_a ^ (^b_data)) == odd_sel);
    end
    if (par_off_n === 1'b0 && a_dir_n === 1'b1 && b_dir_n === 1'b1) begin
      a_r4_isolate: assert (a_err_vld && b_err_vld && par_to_b == a_par && par_to_a == b_par);
    end
    if (par_off_n === 1'b0 && a_dir_n === 1'b0 && b_dir_n === 1'b0) begin
      a_r5_both_gen: assert (!a_err_vld && !b_err_vld);
    end
    if (a_err_vld === 1'b1) begin
      a_r8_r9_err_a: assert (a_err_n == ((^{a_data, a_par}) == odd_sel));
    end
    if (b_err_vld === 1'b1) begin
      a_r8_r9_err_b: assert (b_err_n == ((^{b_data, b_par}) == odd_sel));
    end
    if (a_err_vld === 1'b0) begin
      a_r10_idle_a: assert (a_err_n);
    end
    if (b_err_vld === 1'b0) begin
      a_r10_idle_b: assert (b_err_n);
    end
  end

endmodule

bind lane_parity_unit lane_parity_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lane_parity_unit_test.sv
module lane_parity_unit_test;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_off_n, odd_sel, a_dir_n, b_dir_n, a_par, b_par;
  logic [W-1:0] a_data, b_data;
  logic par_to_b, par_to_a, a_err_n, a_err_vld, b_err_n, b_err_vld;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_parity_unit #(.DATA_W(W)) uut (
    .par_off_n(par_off_n), .odd_sel(odd_sel), .a_dir_n(a_dir_n), .b_dir_n(b_dir_n),
    .a_data(a_data), .a_par(a_par), .b_data(b_data), .b_par(b_par),
    .par_to_b(par_to_b), .par_to_a(par_to_a),
    .a_err_n(a_err_n), .a_err_vld(a_err_vld), .b_err_n(b_err_n), .b_err_vld(b_err_vld)
  );

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic cmp(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Behavioural reference, compared at the falling edge after inputs settle.
  task automatic check_all();
    string req;
    bit en, chk_a, chk_b, gn_a, gn_b;
    logic e_pb, e_pa, e_ea, e_eb;
    int ta, tb;
    en = (par_off_n == 1'b0);
    if (!en) req = "R1";
    else if (!a_dir_n && b_dir_n) req = "R2";
    else if (a_dir_n && !b_dir_n) req = "R3";
    else if (a_dir_n && b_dir_n) req = "R4";
    else req = "R5";
    chk_a = en && b_dir_n;
    chk_b = en && a_dir_n;
    gn_b = en && !a_dir_n;
    gn_a = en && !b_dir_n;
    // R6 even: 1 when ones odd; R7 odd inverts
    e_pb = gn_b ? (((ones(a_data) % 2) == 1) != odd_sel) : a_par;
    e_pa = gn_a ? (((ones(b_data) % 2) == 1) != odd_sel) : b_par;
    ta = ones(a_data) + int'(a_par);
    tb = ones(b_data) + int'(b_par);
    // R8 even: ok when total even; R9 odd: ok when total odd; R10 idle high
    e_ea = chk_a ? (((ta % 2) == 1) == odd_sel) : 1'b1;
    e_eb = chk_b ? (((tb % 2) == 1) == odd_sel) : 1'b1;
    cmp(req, "a_err_vld", a_err_vld, chk_a);
    cmp(req, "b_err_vld", b_err_vld, chk_b);
    cmp(gn_b ? (odd_sel ? "R7" : "R6") : req, "par_to_b", par_to_b, e_pb);
    cmp(gn_a ? (odd_sel ? "R7" : "R6") : req, "par_to_a", par_to_a, e_pa);
    cmp(chk_a ? (odd_sel ? "R9" : "R8") : "R10", "a_err_n", a_err_n, e_ea);
    cmp(chk_b ? (odd_sel ? "R9" : "R8") : "R10", "b_err_n", b_err_n, e_eb);
  endtask

  task automatic apply(input logic [3:0] ctl, input logic [W-1:0] ad, input logic ap,
                       input logic [W-1:0] bd, input logic bp);
    @(posedge clk);
    #1;
    {par_off_n, odd_sel, a_dir_n, b_dir_n} = ctl;
    a_data = ad; a_par = ap; b_data = bd; b_par = bp;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    {par_off_n, odd_sel, a_dir_n, b_dir_n} = 4'b1011;
    a_data = '0; a_par = 1'b0; b_data = '0; b_par = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // reset-time pattern: parity disabled, R1 pass-through
    check_all();
    cmp("R1", "par_to_a reset", par_to_a, 1'b1);

    // directed corners: every control combination against edge words
    for (int c = 0; c < 16; c++) begin
      apply(4'(c), '0, 1'b0, '1, 1'b0);
      apply(4'(c), '1, 1'b1, '0, 1'b1);
      apply(4'(c), 8'h01, 1'b1, 8'h80, 1'b0);
      apply(4'(c), 8'h7F, 1'b0, 8'hFE, 1'b1);
    end
    // single-bit sweep to catch any dropped bit in the folds
    for (int b = 0; b < W; b++) begin
      apply(4'b0001, 8'(1 << b), 1'b0, 8'(1 << b), 1'b1);
      apply(4'b0110, 8'(1 << b), 1'b1, 8'(1 << b), 1'b0);
      apply(4'b0011, 8'(1 << b), 1'b1, 8'(1 << b), 1'b1);
    end
    // R1: parity off with wrong parity still passes bits and leaves flags idle
    apply(4'b1011, 8'h03, 1'b1, 8'h07, 1'b0);
    cmp("R1", "par_to_b raw", par_to_b, 1'b1);
    cmp("R1", "par_to_a raw", par_to_a, 1'b0);
    // random mix
    for (int k = 0; k < 1500; k++) begin
      apply(4'($urandom), 8'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule